// File: doc/BRIEF.md
# Engine Run/Pause State Controller

This block holds the operating state of a queue-fed serial engine. There are three states. **RESET** means the engine is idle and its queues are cleared. **RUN** means the engine takes commands from the output queue and fills the input queue. **PAUSE** means the engine is frozen, so software can load the output queue without any entry being used; a later return to RUN starts execution.

Software asks for a new state by writing a 2-bit code. The block checks whether the move is legal. For every accepted move, it pulls a settle flag low for `SETTLE_CYC` cycles. During that window the queue pointers and the engine can line up before the new state takes effect. Software polls the status word until the target code reads back with the settle flag high.

A software-reset strobe forces the block to RESET from any state. The status word also carries a master-ready bit, which tells software when the engine can accept a new transfer.

The FSM has these states and transitions:
- States: `ST_RESET`, `ST_RUN`, `ST_PAUSE`.
- Legal transitions:
  - RESET→RUN (start)
  - RUN→PAUSE (hold)
  - PAUSE→RUN (resume)
  - RUN→RESET (abort)
  - PAUSE→RESET (abort)
- Forced transition: any→RESET on the software-reset strobe.

Top module: `engine_state_ctl`

## Requirements
- R1: After `rst_n` is released, `status[1:0]` reads 00 (RESET), `status[2]` (settle flag) reads 1, and both `fetch_en` and `push_en` are 0.
- R2: An accepted write sets `status[1:0]` to the written code from the clock edge that accepts it. `status[2]` then reads 0 for exactly `SETTLE_CYC` cycles (default 3) and reads 1 after that.
- R3: The block accepts these writes: code 01 from RESET or PAUSE, code 11 from RUN, and code 00 from RUN or PAUSE.
- R4: A write of code 11 (PAUSE) while in RESET is ignored. The state stays 00 and `status[2]` stays 1.
- R5: A write of the unused code 10, or of the current state's own code, is ignored. The state does not change, `status[2]` does not drop, and `svc_clear` does not pulse.
- R6: Any state write made while `status[2]` is 0 is ignored.
- R7: `fetch_en` and `push_en` are 1 only when the state is RUN and `status[2]` is 1. They are 0 in PAUSE and in RESET.
- R8: `sw_reset` forces the state to RESET with `status[2]` low for `SETTLE_CYC` cycles. It wins over a state write in the same cycle, and it pulses `svc_clear` for one cycle.
- R9: An accepted write of RESET (00) also pulses `svc_clear` for one cycle.
- R10: `status[4]` (master ready) is 1 only when `status[2]` is 1 and `eng_idle` was high on the previous cycle. `status[3]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_wr_en | input | 1 | State write strobe |
| st_wr_code | input | 2 | Requested state code |
| sw_reset | input | 1 | Software reset strobe |
| eng_idle | input | 1 | Serial engine reports it can take a transfer |
| status | output | 5 | {master ready, 0, settle flag, state[1:0]} |
| fetch_en | output | 1 | Output-queue command fetch enable |
| push_en | output | 1 | Input-queue write enable |
| svc_clear | output | 1 | One-cycle pulse clearing the service flags |

## Verification
The bench tests these corner cases:
- **PAUSE requested from RESET.** A design without the legality check would freeze an idle engine and report a state it never reached.
- **Writes made during the settle window.** If these were not dropped, a second transition would cut the synchronisation window short.
- **Software reset raised in the same cycle as a state write.** If the write won, the block would land in PAUSE instead of RESET.
- **Exact length of the low settle window.** An off-by-one counter would release `fetch_en` one cycle early or late.
- **Writes of the current state or of the unused code 10.** A design that handled these wrongly would drop the settle flag or pulse `svc_clear` for nothing.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'b00,
        ST_RUN   = 2'b01,
        ST_PAUSE = 2'b11
    } run_state_e;

    localparam int STATUS_W = 5;
endpackage

// File: rtl/rpc_legal.sv
module rpc_legal
    import rpc_pkg::*;
(
    input  run_state_e cur,
    input  logic [1:0] req,
    output logic       accept
);
    always_comb begin
        accept = 1'b0;
        unique case (cur)
            ST_RESET: accept = (req == 2'b01);
            ST_RUN:   accept = (req == 2'b00) || (req == 2'b11);
            ST_PAUSE: accept = (req == 2'b00) || (req == 2'b01);
            default:  accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/rpc_settle.sv
module rpc_settle #(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic idle
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (cnt_q == '0);

    // R2: the window never exceeds its configured length
    a_r2_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL);

    // R2: every accepted move opens a full window
    a_r2_settle_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/rpc_gate.sv
module rpc_gate
    import rpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  run_state_e st,
    input  logic       settled,
    input  logic       eng_idle,
    output logic       fetch_en,
    output logic       push_en,
    output logic       mst_rdy
);
    logic eng_idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_idle_q <= 1'b0;
        end else begin
            eng_idle_q <= eng_idle;
        end
    end

    always_comb begin
        fetch_en = 1'b0;
        push_en  = 1'b0;
        unique case (st)
            ST_RUN: begin
                fetch_en = settled;
                push_en  = settled;
            end
            ST_RESET, ST_PAUSE: begin
                fetch_en = 1'b0;
                push_en  = 1'b0;
            end
            default: begin
                fetch_en = 1'b0;
                push_en  = 1'b0;
            end
        endcase
        mst_rdy = settled & eng_idle_q;
    end
endmodule

// File: rtl/engine_state_ctl.sv
module engine_state_ctl
    import rpc_pkg::*;
#(
    parameter int SETTLE_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_wr_en,
    input  logic [1:0]          st_wr_code,
    input  logic                sw_reset,
    input  logic                eng_idle,
    output logic [STATUS_W-1:0] status,
    output logic                fetch_en,
    output logic                push_en,
    output logic                svc_clear
);
    run_state_e st_q, st_d;
    logic       legal, settled, take_wr, load, mst_rdy, clr_d, clr_q;

    rpc_legal u_legal (
        .cur    (st_q),
        .req    (st_wr_code),
        .accept (legal)
    );

    rpc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .idle  (settled)
    );

    rpc_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st_q),
        .settled  (settled),
        .eng_idle (eng_idle),
        .fetch_en (fetch_en),
        .push_en  (push_en),
        .mst_rdy  (mst_rdy)
    );

    assign take_wr = st_wr_en & settled & legal;
    assign load    = sw_reset | take_wr;

    always_comb begin
        st_d  = st_q;
        clr_d = 1'b0;
        if (sw_reset) begin
            st_d  = ST_RESET;
            clr_d = 1'b1;
        end else if (take_wr) begin
            st_d  = run_state_e'(st_wr_code);
            clr_d = (st_wr_code == 2'b00);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RESET;
            clr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            clr_q <= clr_d;
        end
    end

    assign status    = {mst_rdy, 1'b0, settled, st_q};
    assign svc_clear = clr_q;

    // R4: PAUSE is reached only from RUN
    a_r4_pause_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PAUSE && $past(st_q) != ST_PAUSE) |-> ($past(st_q) == ST_RUN));

    // R6: state is frozen while settling unless a software reset arrives
    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!settled && !sw_reset) |=> (st_q == $past(st_q)));

    // R7: the engine moves only in a settled RUN state
    a_r7_fetch_only_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en || push_en) |-> (st_q == ST_RUN && settled));

    // R8: software reset lands in RESET with the window open and a clear pulse
    a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (st_q == ST_RESET && !settled && svc_clear));
endmodule

// File: tb/engine_state_ctl_tb.sv
module engine_state_ctl_tb;
    localparam int SC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       st_wr_en = 1'b0;
    logic [1:0] st_wr_code = 2'b00;
    logic       sw_reset = 1'b0;
    logic       eng_idle = 1'b1;
    logic [4:0] status;
    logic       fetch_en, push_en, svc_clear;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    engine_state_ctl #(.SETTLE_CYC(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_wr_code(st_wr_code),
        .sw_reset(sw_reset), .eng_idle(eng_idle), .status(status),
        .fetch_en(fetch_en), .push_en(push_en), .svc_clear(svc_clear)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a negedge, return at the next negedge with the write removed
    task automatic wr(input logic [1:0] code);
        st_wr_en   = 1'b1;
        st_wr_code = code;
        @(negedge clk);
        st_wr_en   = 1'b0;
    endtask

    task automatic settle_wait();
        repeat (SC) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 state", 32'(status[1:0]), 32'h0);
        chk("R1 valid", 32'(status[2]), 32'h1);
        chk("R1 fetch", 32'(fetch_en), 32'h0);
        chk("R1 push", 32'(push_en), 32'h0);
    endtask

    task automatic t_illegal();
        wr(2'b11);
        chk("R4 state", 32'(status[1:0]), 32'h0);
        chk("R4 valid", 32'(status[2]), 32'h1);
        wr(2'b10);
        chk("R5 code10 state", 32'(status[1:0]), 32'h0);
        chk("R5 code10 valid", 32'(status[2]), 32'h1);
        wr(2'b00);
        chk("R5 same valid", 32'(status[2]), 32'h1);
        chk("R5 same clr", 32'(svc_clear), 32'h0);
    endtask

    task automatic t_run_and_busy();
        wr(2'b01);
        chk("R2 state", 32'(status[1:0]), 32'h1);
        chk("R2 valid low 1", 32'(status[2]), 32'h0);
        chk("R7 fetch busy", 32'(fetch_en), 32'h0);
        chk("R10 rdy busy", 32'(status[4]), 32'h0);
        wr(2'b00); // R6: dropped, window still open
        chk("R6 state", 32'(status[1:0]), 32'h1);
        chk("R2 valid low 2", 32'(status[2]), 32'h0);
        @(negedge clk);
        chk("R2 valid low 3", 32'(status[2]), 32'h0);
        @(negedge clk);
        chk("R2 valid high", 32'(status[2]), 32'h1);
        chk("R6 state kept", 32'(status[1:0]), 32'h1);
        chk("R7 fetch run", 32'(fetch_en), 32'h1);
        chk("R7 push run", 32'(push_en), 32'h1);
        chk("R3 svc quiet", 32'(svc_clear), 32'h0);
    endtask

    task automatic t_pause_resume();
        wr(2'b11);
        chk("R3 pause", 32'(status[1:0]), 32'h3);
        settle_wait();
        chk("R3 pause valid", 32'(status[2]), 32'h1);
        chk("R7 fetch pause", 32'(fetch_en), 32'h0);
        chk("R7 push pause", 32'(push_en), 32'h0);
        wr(2'b01);
        chk("R3 resume", 32'(status[1:0]), 32'h1);
        settle_wait();
        chk("R3 resume fetch", 32'(fetch_en), 32'h1);
    endtask

    task automatic t_master_ready();
        eng_idle = 1'b0;
        @(negedge clk);
        chk("R10 not idle", 32'(status[4]), 32'h0);
        eng_idle = 1'b1;
        @(negedge clk);
        chk("R10 idle", 32'(status[4]), 32'h1);
        chk("R10 bit3", 32'(status[3]), 32'h0);
    endtask

    task automatic t_write_reset();
        wr(2'b00);
        chk("R9 state", 32'(status[1:0]), 32'h0);
        chk("R9 clr", 32'(svc_clear), 32'h1);
        @(negedge clk);
        chk("R9 clr one cycle", 32'(svc_clear), 32'h0);
        repeat (SC - 1) @(negedge clk);
        chk("R9 valid back", 32'(status[2]), 32'h1);
    endtask

    task automatic t_soft_reset();
        wr(2'b01);
        settle_wait();
        chk("R8 pre run", 32'(status[1:0]), 32'h1);
        sw_reset   = 1'b1;
        st_wr_en   = 1'b1;
        st_wr_code = 2'b11;
        @(negedge clk);
        sw_reset = 1'b0;
        st_wr_en = 1'b0;
        chk("R8 state", 32'(status[1:0]), 32'h0);
        chk("R8 valid", 32'(status[2]), 32'h0);
        chk("R8 clr", 32'(svc_clear), 32'h1);
        chk("R8 fetch", 32'(fetch_en), 32'h0);
        repeat (SC - 1) @(negedge clk);
        chk("R8 valid low last", 32'(status[2]), 32'h0);
        @(negedge clk);
        chk("R8 valid high", 32'(status[2]), 32'h1);
        chk("R8 clr gone", 32'(svc_clear), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_illegal();
        t_run_and_busy();
        t_pause_resume();
        t_master_ready();
        t_write_reset();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule